// File: doc/BRIEF.md
# Centralized Scoreboard Issue Controller

This block is the hazard-tracking brain of a core whose functional units are not pipelined. A decoder offers it one instruction at a time: a unit class, an opcode, a destination register and two source registers. The controller takes each accepted instruction through four steps. It issues the instruction to a free unit, grants it the register-file read once both operands are safe, lets it run until the unit reports completion, and grants the register-file write once no older reader still needs the old value of the destination.

Instructions are named by the unit that holds them, so the window is one entry per unit. Three pieces of state drive every decision. A per-unit stage records where each instruction is. A per-unit status record holds the opcode, the registers, the producing-unit tags of the sources and their ready bits. A per-register table names the unit that will write each register. There is no commit step, and an interrupt does not see a precise state.

Six units are configured. Units 0 and 1 multiply, unit 2 adds, unit 3 divides, unit 4 does integer work and unit 5 loads. Arithmetic, fetch and memory live outside the block.

Top module: `sb_ctrl`

## Requirements
- R1: Class codes are multiply=0, add=1, divide=2, integer=3, load=4, served by units {0,1}, {2}, {3}, {4}, {5}. `iss_fu` names the lowest-numbered idle unit of the offered class. `in_ready` is low when every unit of that class is busy.
- R2: `in_ready` is low while the offered destination register has a pending producer, that is, an issued instruction that has not yet been granted its write.
- R3: A waiting unit is granted the read (`rd_valid`, with `rd_fu`, `rd_op`, `rd_src1`, `rd_src2`) only when both of its sources are ready. At most one unit is granted the read per cycle.
- R4: A write grant makes ready, from the next cycle on, every waiting source that was tagged with the writing unit. A source whose producer is granted its write in the very cycle the consumer issues counts as ready at issue.
- R5: A completion pulse on `fu_done[i]` counts only while unit i has read its operands and is executing. Pulses at any other time are ignored.
- R6: A finished unit is not granted its write while another unit is still waiting to read, with its ready bit set, a source equal to that destination.
- R7: At most one write is granted per cycle (`wb_valid`, `wb_fu`, `wb_dst`). Among finished units that are not held by R6, the one that finished first wins. Units that finish in the same cycle are ordered lowest number first.
- R8: A write grant frees the unit and clears the destination's pending producer, so the unit's class and that destination can issue in the next cycle.
- R9: After reset every unit is idle and no register has a producer. `rd_valid` and `wb_valid` are low, and any class is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction offered |
| in_class | input | 3 | Unit class of the instruction |
| in_op | input | 4 | Opcode passed to the unit |
| in_dst | input | 4 | Destination register |
| in_src1 | input | 4 | First source register |
| in_src2 | input | 4 | Second source register |
| in_ready | output | 1 | Offered instruction can issue this cycle |
| iss_fu | output | 3 | Unit that receives the issue |
| rd_valid | output | 1 | Register-file read granted |
| rd_fu | output | 3 | Unit granted the read |
| rd_op | output | 4 | Opcode of the reading unit |
| rd_src1 | output | 4 | First register to read |
| rd_src2 | output | 4 | Second register to read |
| fu_done | input | 6 | Per-unit completion pulses |
| wb_valid | output | 1 | Register-file write granted |
| wb_fu | output | 3 | Unit granted the write |
| wb_dst | output | 4 | Register being written |

## Verification
The bench goes after the cycle in which a producer writes while a consumer of that register issues. A design without the issue-time bypass leaves the consumer waiting forever, and the read it expects never comes. It builds a write-after-read case: a consumer holds a ready but unread copy of a register while a later unit that targets the same register finishes. A design that misses this lets the later result overwrite the register first. It queues two finished units whose finish order is the reverse of their unit numbers, which catches a plain lowest-number arbiter. It also pulses completion into a unit that is still waiting and into an idle unit. A design that honours such pulses grants writes that no execution produced.

// File: rtl/sb_pkg.sv
package sb_pkg;

    localparam int NUM_FU  = 6;
    localparam int FU_W    = $clog2(NUM_FU);
    localparam int NUM_REG = 16;
    localparam int REG_W   = $clog2(NUM_REG);
    localparam int OP_W    = 4;
    localparam int CLS_W   = 3;

    typedef enum logic [CLS_W-1:0] {
        CL_MUL  = 3'd0,
        CL_ADD  = 3'd1,
        CL_DIV  = 3'd2,
        CL_INT  = 3'd3,
        CL_LOAD = 3'd4
    } fu_class_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_OPS = 2'd1,
        ST_EXEC     = 2'd2,
        ST_DONE     = 2'd3
    } stage_e;

    typedef struct packed {
        logic            vld;
        logic [FU_W-1:0] fu;
    } tag_t;

    typedef struct packed {
        stage_e           stage;
        logic [OP_W-1:0]  op;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src1;
        logic [REG_W-1:0] src2;
        tag_t             q1;
        tag_t             q2;
        logic             r1;
        logic             r2;
    } fu_entry_t;

    function automatic fu_class_e class_of_unit(input int idx);
        case (idx)
            0, 1:    return CL_MUL;
            2:       return CL_ADD;
            3:       return CL_DIV;
            4:       return CL_INT;
            default: return CL_LOAD;
        endcase
    endfunction

endpackage

// File: rtl/sb_fu_entry.sv
module sb_fu_entry
    import sb_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            iss_en,
    input  fu_entry_t       iss_ent,
    input  logic            rd_en,
    input  logic            done_in,
    input  logic            wb_en,
    input  logic            bc_vld,
    input  logic [FU_W-1:0] bc_fu,
    output fu_entry_t       ent
);
    logic hit1, hit2;

    assign hit1 = bc_vld && ent.q1.vld && !ent.r1 && (ent.q1.fu == bc_fu);
    assign hit2 = bc_vld && ent.q2.vld && !ent.r2 && (ent.q2.fu == bc_fu);

    always_ff @(posedge clk) begin
        if (rst) begin
            ent <= '0;
        end else begin
            case (ent.stage)
                ST_IDLE: begin
                    if (iss_en) begin
                        ent       <= iss_ent;
                        ent.stage <= ST_WAIT_OPS;
                    end
                end
                ST_WAIT_OPS: begin
                    if (hit1) begin
                        ent.r1     <= 1'b1;
                        ent.q1.vld <= 1'b0;
                    end
                    if (hit2) begin
                        ent.r2     <= 1'b1;
                        ent.q2.vld <= 1'b0;
                    end
                    if (rd_en) ent.stage <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (done_in) ent.stage <= ST_DONE;
                end
                default: begin
                    if (wb_en) ent.stage <= ST_IDLE;
                end
            endcase
        end
    end
endmodule

// File: rtl/sb_regmap.sv
module sb_regmap
    import sb_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     set_en,
    input  logic [REG_W-1:0]         set_reg,
    input  logic [FU_W-1:0]          set_fu,
    input  logic                     clr_en,
    input  logic [REG_W-1:0]         clr_reg,
    output tag_t [NUM_REG-1:0]       map_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            map_o <= '0;
        end else begin
            if (clr_en) map_o[clr_reg].vld <= 1'b0;
            if (set_en) begin
                map_o[set_reg].vld <= 1'b1;
                map_o[set_reg].fu  <= set_fu;
            end
        end
    end
endmodule

// File: rtl/sb_wb_arb.sv
module sb_wb_arb
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_FU-1:0] fin,
    input  logic [NUM_FU-1:0] pend,
    input  logic [NUM_FU-1:0] elig,
    output logic              grant_vld,
    output logic [FU_W-1:0]   grant_fu
);
    localparam int MAT = NUM_FU * NUM_FU;

    // older[a*NUM_FU+b] set: unit a finished before unit b
    logic [MAT-1:0] older;

    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int a = 0; a < NUM_FU; a++) begin
                for (int b = 0; b < NUM_FU; b++) begin
                    if (a != b) begin
                        if (fin[a])
                            older[a*NUM_FU+b] <= !pend[b] && !(fin[b] && (b < a));
                        else if (fin[b])
                            older[a*NUM_FU+b] <= 1'b1;
                    end
                end
            end
        end
    end

    always_comb begin
        logic beats_all;
        grant_vld = 1'b0;
        grant_fu  = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            beats_all = elig[i];
            for (int j = 0; j < NUM_FU; j++) begin
                if (j != i && elig[j] && !older[i*NUM_FU+j]) beats_all = 1'b0;
            end
            if (beats_all) begin
                grant_vld = 1'b1;
                grant_fu  = FU_W'(i);
            end
        end
    end
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [CLS_W-1:0]  in_class,
    input  logic [OP_W-1:0]   in_op,
    input  logic [REG_W-1:0]  in_dst,
    input  logic [REG_W-1:0]  in_src1,
    input  logic [REG_W-1:0]  in_src2,
    output logic              in_ready,
    output logic [FU_W-1:0]   iss_fu,
    output logic              rd_valid,
    output logic [FU_W-1:0]   rd_fu,
    output logic [OP_W-1:0]   rd_op,
    output logic [REG_W-1:0]  rd_src1,
    output logic [REG_W-1:0]  rd_src2,
    input  logic [NUM_FU-1:0] fu_done,
    output logic              wb_valid,
    output logic [FU_W-1:0]   wb_fu,
    output logic [REG_W-1:0]  wb_dst
);
    fu_entry_t          ent [NUM_FU];
    tag_t [NUM_REG-1:0] rmap;

    logic               cand_hit;
    logic               iss_fire;
    fu_entry_t          iss_ent;
    logic               src1_rdy, src2_rdy;
    logic [NUM_FU-1:0]  war_block, fin_vec, pend_vec, elig_vec;

    // unit selection for the offered class
    always_comb begin
        cand_hit = 1'b0;
        iss_fu   = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (class_of_unit(i) == fu_class_e'(in_class) && ent[i].stage == ST_IDLE) begin
                cand_hit = 1'b1;
                iss_fu   = FU_W'(i);
            end
        end
    end

    assign in_ready = cand_hit && !rmap[in_dst].vld;
    assign iss_fire = in_valid && in_ready;

    // source readiness, with bypass of a write granted this cycle
    assign src1_rdy = !rmap[in_src1].vld || (wb_valid && rmap[in_src1].fu == wb_fu);
    assign src2_rdy = !rmap[in_src2].vld || (wb_valid && rmap[in_src2].fu == wb_fu);

    always_comb begin
        iss_ent       = '0;
        iss_ent.stage = ST_WAIT_OPS;
        iss_ent.op    = in_op;
        iss_ent.dst   = in_dst;
        iss_ent.src1  = in_src1;
        iss_ent.src2  = in_src2;
        iss_ent.r1    = src1_rdy;
        iss_ent.r2    = src2_rdy;
        iss_ent.q1    = src1_rdy ? '0 : rmap[in_src1];
        iss_ent.q2    = src2_rdy ? '0 : rmap[in_src2];
    end

    // single register-file read port, lowest unit first
    always_comb begin
        rd_valid = 1'b0;
        rd_fu    = '0;
        for (int i = NUM_FU - 1; i >= 0; i--) begin
            if (ent[i].stage == ST_WAIT_OPS && ent[i].r1 && ent[i].r2) begin
                rd_valid = 1'b1;
                rd_fu    = FU_W'(i);
            end
        end
    end

    assign rd_op   = ent[rd_fu].op;
    assign rd_src1 = ent[rd_fu].src1;
    assign rd_src2 = ent[rd_fu].src2;

    // write-after-read hold
    always_comb begin
        for (int i = 0; i < NUM_FU; i++) begin
            war_block[i] = 1'b0;
            for (int j = 0; j < NUM_FU; j++) begin
                if (j != i && ent[j].stage == ST_WAIT_OPS &&
                    ((ent[j].r1 && ent[j].src1 == ent[i].dst) ||
                     (ent[j].r2 && ent[j].src2 == ent[i].dst)))
                    war_block[i] = 1'b1;
            end
            fin_vec[i]  = ent[i].stage == ST_EXEC && fu_done[i];
            pend_vec[i] = ent[i].stage == ST_DONE;
        end
    end

    assign elig_vec = pend_vec & ~war_block;
    assign wb_dst   = ent[wb_fu].dst;

    sb_wb_arb u_arb (
        .clk       (clk),
        .rst       (rst),
        .fin       (fin_vec),
        .pend      (pend_vec),
        .elig      (elig_vec),
        .grant_vld (wb_valid),
        .grant_fu  (wb_fu)
    );

    sb_regmap u_map (
        .clk     (clk),
        .rst     (rst),
        .set_en  (iss_fire),
        .set_reg (in_dst),
        .set_fu  (iss_fu),
        .clr_en  (wb_valid),
        .clr_reg (wb_dst),
        .map_o   (rmap)
    );

    for (genvar g = 0; g < NUM_FU; g++) begin : g_unit
        sb_fu_entry u_ent (
            .clk     (clk),
            .rst     (rst),
            .iss_en  (iss_fire && iss_fu == FU_W'(g)),
            .iss_ent (iss_ent),
            .rd_en   (rd_valid && rd_fu == FU_W'(g)),
            .done_in (fu_done[g]),
            .wb_en   (wb_valid && wb_fu == FU_W'(g)),
            .bc_vld  (wb_valid),
            .bc_fu   (wb_fu),
            .ent     (ent[g])
        );
    end
endmodule

// File: rtl/sb_ctrl_checker.sv
module sb_ctrl_checker
    import sb_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               in_valid,
    input logic               in_ready,
    input logic [REG_W-1:0]   in_dst,
    input logic [FU_W-1:0]    iss_fu,
    input logic               rd_valid,
    input logic [FU_W-1:0]    rd_fu,
    input logic               wb_valid,
    input logic [FU_W-1:0]    wb_fu,
    input logic [REG_W-1:0]   wb_dst,
    input fu_entry_t          ent [NUM_FU],
    input tag_t [NUM_REG-1:0] rmap
);
    logic war_clear;

    always_comb begin
        war_clear = 1'b1;
        for (int j = 0; j < NUM_FU; j++) begin
            if (FU_W'(j) != wb_fu && ent[j].stage == ST_WAIT_OPS &&
                ((ent[j].r1 && ent[j].src1 == wb_dst) || (ent[j].r2 && ent[j].src2 == wb_dst)))
                war_clear = 1'b0;
        end
    end

    a_r1_issue_to_idle: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> ent[iss_fu].stage == ST_IDLE);

    a_r2_no_waw_issue: assert property (@(posedge clk) disable iff (rst)
        in_valid && in_ready |-> !rmap[in_dst].vld);

    a_r3_read_starts_exec: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> ent[$past(rd_fu)].stage == ST_EXEC);

    a_r6_no_war_write: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> war_clear);

    a_r7_write_from_done: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> ent[wb_fu].stage == ST_DONE);

    a_r8_write_frees: assert property (@(posedge clk) disable iff (rst)
        wb_valid |=> ent[$past(wb_fu)].stage == ST_IDLE && !rmap[$past(wb_dst)].vld);

    for (genvar g = 0; g < NUM_FU; g++) begin : g_chk
        a_r5_done_after_exec: assert property (@(posedge clk) disable iff (rst)
            ent[g].stage == ST_DONE |->
                ($past(ent[g].stage) == ST_EXEC || $past(ent[g].stage) == ST_DONE));
    end
endmodule

bind sb_ctrl sb_ctrl_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_dst   (in_dst),
    .iss_fu   (iss_fu),
    .rd_valid (rd_valid),
    .rd_fu    (rd_fu),
    .wb_valid (wb_valid),
    .wb_fu    (wb_fu),
    .wb_dst   (wb_dst),
    .ent      (ent),
    .rmap     (rmap)
);

// File: tb/sb_ctrl_bench.sv
module sb_ctrl_bench;
    import sb_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              in_valid = 1'b0;
    logic [CLS_W-1:0]  in_class = '0;
    logic [OP_W-1:0]   in_op = '0;
    logic [REG_W-1:0]  in_dst = '0, in_src1 = '0, in_src2 = '0;
    logic              in_ready;
    logic [FU_W-1:0]   iss_fu;
    logic              rd_valid;
    logic [FU_W-1:0]   rd_fu;
    logic [OP_W-1:0]   rd_op;
    logic [REG_W-1:0]  rd_src1, rd_src2;
    logic [NUM_FU-1:0] fu_done = '0;
    logic              wb_valid;
    logic [FU_W-1:0]   wb_fu;
    logic [REG_W-1:0]  wb_dst;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    sb_ctrl u_sb_ctrl (.*);

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        in_valid = 1'b0;
        fu_done  = '0;
        #1;
    endtask

    task automatic offer(input logic [2:0] cls, input int op, input int dst, input int s1, input int s2);
        in_valid = 1'b1;
        in_class = cls;
        in_op    = OP_W'(op);
        in_dst   = REG_W'(dst);
        in_src1  = REG_W'(s1);
        in_src2  = REG_W'(s2);
        #1;
    endtask

    task automatic drain();
        repeat (30) begin
            fu_done = '1;
            step();
        end
    endtask

    task automatic t_reset();
        offer(3'd1, 0, 1, 0, 0);
        in_valid = 1'b0;
        chk("R9", "in_ready", in_ready, 1);
        chk("R9", "rd_valid", rd_valid, 0);
        chk("R9", "wb_valid", wb_valid, 0);
    endtask

    task automatic t_basic();
        offer(3'd1, 5, 1, 2, 3);
        chk("R1", "add unit", iss_fu, 2);
        step();
        chk("R3", "rd_valid", rd_valid, 1);
        chk("R3", "rd_fu", rd_fu, 2);
        chk("R3", "rd_op", rd_op, 5);
        chk("R3", "rd_src1", rd_src1, 2);
        chk("R3", "rd_src2", rd_src2, 3);
        step();
        chk("R3", "rd_valid after read", rd_valid, 0);
        fu_done[2] = 1'b1;
        step();
        chk("R7", "wb_valid", wb_valid, 1);
        chk("R7", "wb_fu", wb_fu, 2);
        chk("R7", "wb_dst", wb_dst, 1);
        in_class = 3'd1; in_dst = 4'd9; #1;
        chk("R1", "add busy stalls", in_ready, 0);
        step();
        chk("R8", "add free after write", in_ready, 1);
        chk("R8", "wb_valid clear", wb_valid, 0);
        drain();
    endtask

    task automatic t_busy();
        offer(3'd0, 1, 4, 0, 0);
        chk("R1", "first mul", iss_fu, 0);
        step();
        offer(3'd0, 1, 5, 0, 0);
        chk("R1", "second mul", iss_fu, 1);
        chk("R1", "second mul ready", in_ready, 1);
        step();
        offer(3'd0, 1, 6, 0, 0);
        chk("R1", "third mul stalls", in_ready, 0);
        step();
        drain();
    endtask

    task automatic t_waw();
        offer(3'd3, 2, 3, 0, 0);
        chk("R1", "int unit", iss_fu, 4);
        step();
        offer(3'd4, 3, 3, 0, 0);
        chk("R2", "waw stall", in_ready, 0);
        step();
        fu_done[4] = 1'b1;
        chk("R2", "waw stall during exec", in_ready, 0);
        step();
        chk("R2", "waw stall in write cycle", in_ready, 0);
        chk("R7", "int writes", wb_fu, 4);
        step();
        chk("R8", "dest free after write", in_ready, 1);
        chk("R1", "load unit", iss_fu, 5);
        drain();
    endtask

    task automatic t_raw();
        offer(3'd2, 4, 2, 0, 0);
        chk("R1", "div unit", iss_fu, 3);
        step();
        offer(3'd1, 6, 6, 2, 0);
        chk("R3", "div reads", rd_fu, 3);
        step();
        chk("R3", "consumer waits", rd_valid, 0);
        fu_done[3] = 1'b1;
        step();
        chk("R7", "div writes", wb_valid, 1);
        chk("R4", "no read before write", rd_valid, 0);
        step();
        chk("R4", "consumer woken", rd_valid, 1);
        chk("R4", "consumer unit", rd_fu, 2);
        chk("R4", "consumer src1", rd_src1, 2);
        drain();
    endtask

    task automatic t_bypass();
        offer(3'd2, 4, 2, 0, 0);
        step();
        step();
        fu_done[3] = 1'b1;
        step();
        chk("R7", "div write grant", wb_valid, 1);
        offer(3'd1, 6, 6, 2, 0);
        chk("R4", "consumer issues in write cycle", in_ready, 1);
        step();
        chk("R4", "bypassed consumer reads", rd_valid, 1);
        chk("R4", "bypassed consumer unit", rd_fu, 2);
        drain();
    endtask

    task automatic t_ignore_done();
        offer(3'd3, 2, 7, 0, 0);
        step();
        fu_done[4] = 1'b1;
        step();
        chk("R5", "done while waiting ignored", wb_valid, 0);
        fu_done[5] = 1'b1;
        step();
        chk("R5", "done to idle ignored", wb_valid, 0);
        fu_done[4] = 1'b1;
        step();
        chk("R5", "real done honoured", wb_valid, 1);
        chk("R5", "real done unit", wb_fu, 4);
        step();
        in_class = 3'd4; in_dst = 4'd11; #1;
        chk("R5", "idle load unaffected", in_ready, 1);
        drain();
    endtask

    task automatic t_war();
        offer(3'd2, 4, 2, 0, 0);
        step();
        offer(3'd1, 6, 6, 3, 2);
        step();
        offer(3'd0, 1, 3, 0, 0);
        chk("R2", "mul issue to r3", in_ready, 1);
        step();
        chk("R3", "mul reads", rd_fu, 0);
        step();
        fu_done[0] = 1'b1;
        step();
        chk("R6", "war hold", wb_valid, 0);
        step();
        chk("R6", "war hold persists", wb_valid, 0);
        fu_done[3] = 1'b1;
        step();
        chk("R6", "div passes held mul", wb_fu, 3);
        chk("R6", "div write grant", wb_valid, 1);
        step();
        chk("R6", "reader granted", rd_fu, 2);
        chk("R6", "mul still held", wb_valid, 0);
        step();
        chk("R6", "mul released", wb_valid, 1);
        chk("R6", "mul unit", wb_fu, 0);
        chk("R6", "mul dest", wb_dst, 3);
        drain();
    endtask

    task automatic t_order();
        offer(3'd4, 3, 8, 0, 0);
        step();
        offer(3'd1, 5, 9, 0, 0);
        step();
        offer(3'd0, 1, 10, 0, 0);
        step();
        step();
        fu_done[5] = 1'b1;
        fu_done[2] = 1'b1;
        step();
        chk("R7", "same-cycle tie lowest", wb_fu, 2);
        fu_done[0] = 1'b1;
        step();
        chk("R7", "oldest finisher first", wb_fu, 5);
        step();
        chk("R7", "youngest last", wb_fu, 0);
        chk("R7", "youngest dest", wb_dst, 10);
        step();
        chk("R7", "queue empty", wb_valid, 0);
        drain();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        t_reset();
        t_basic();
        t_busy();
        t_waw();
        t_raw();
        t_bypass();
        t_ignore_done();
        t_war();
        t_order();
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule